// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic tick timer for a processor subsystem. A 24-bit counter steps down by one on every selected tick. After it has reached zero, the next tick loads it again from a programmable reload register. The period is therefore the reload value plus one ticks. Each arrival at zero sets a sticky wrap flag. When interrupts are enabled, the flag also drives a level interrupt request.

The tick comes either from the core clock, which counts every cycle, or from a slower reference tick. The reference tick arrives as a one-cycle enable pulse generated outside the block. Software reaches three word registers over a simple synchronous register bus: control/status, reload and current value. A delay of D ticks is made by loading D-1 into reload, writing the current register to zero it, and then polling the wrap flag.

The wrap flag is cleared in two ways: by any write to the current-value register, or by a read of the control register. A wrap that happens in the same cycle as a control read is not lost.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control, reload and current registers read as zero and `irq` is low.
- R2: While ENABLE (control bit 0) is 1, the counter decrements by one on each selected tick. While ENABLE is 0, or when no tick is selected, the counter holds its value.
- R3: With SOURCE (control bit 2) at 1, every clock cycle is a tick. With SOURCE at 0, only cycles with `ref_tick` high are ticks.
- R4: A tick that moves the counter from 1 to 0 sets the wrap flag, which reads as control bit 16.
- R5: A tick that finds the counter at 0 loads it from reload and does not set the flag, so a reload value of N gives a period of N+1 ticks.
- R6: Any write to the current register (word 2) zeroes the counter and clears the flag. This clear wins over a wrap in the same cycle.
- R7: A read of the control register (word 0) returns the flag and then clears it, unless a wrap happens in that same cycle, in which case the flag stays set.
- R8: `irq` is high exactly when the flag is set and IRQ_EN (control bit 1) is 1.
- R9: Reload (word 1) and current read back with bits 31:24 as zero. Writes to those bits are ignored.
- R10: With reload at zero, the counter stays at zero and the flag is never set again.
- R11: Control bits other than 0, 1, 2 and 16 read zero and ignore writes. Word 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle reference tick enable |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 control, 1 reload, 2 current |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt request |

## Verification
Directed sequences cover four cases. A delay of five ticks places a control read exactly on the wrap edge, which separates a lost wrap from a kept one. A write to current on the wrap edge shows that the write clear wins. Reference-tick runs with sparse pulses show whether the counter follows `ref_tick` or the core clock. A zero reload shows that the counter does not re-arm. Random traffic then mixes short reload values, toggled enables and source bits, sparse reference pulses and reads of every word, including the unused one. Each read and each cycle of `irq` is compared with a bench model, which catches wrong ordering between reload, flag set and the two clear paths.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_CURRENT = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  localparam int CTRL_ENABLE = 0;
  localparam int CTRL_IRQEN  = 1;
  localparam int CTRL_SOURCE = 2;
  localparam int CTRL_FLAG   = 16;

  // Next counter value on a tick: reload at zero, else step down.
  function automatic logic [63:0] count_next(input logic [63:0] cur, input logic [63:0] rel);
    return (cur == 64'd0) ? rel : cur - 64'd1;
  endfunction

  // A tick from this value lands on zero.
  function automatic logic lands_on_zero(input logic [63:0] cur);
    return cur == 64'd1;
  endfunction

endpackage

// File: rtl/tick_timer_src.sv
module tick_timer_src (
  input  logic enable,
  input  logic src_core,
  input  logic ref_tick,
  output logic tick
);
  logic src_pulse;

  assign src_pulse = src_core ? 1'b1 : ref_tick;
  assign tick      = enable & src_pulse;
endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             zero_hit
);
  localparam int PAD = 64 - CNT_W;

  logic [63:0] cur_wide;
  logic [63:0] rel_wide;
  logic [63:0] nxt_wide;

  assign cur_wide = {{PAD{1'b0}}, count};
  assign rel_wide = {{PAD{1'b0}}, reload_val};
  assign nxt_wide = count_next(cur_wide, rel_wide);
  assign zero_hit = tick & ~clear & lands_on_zero(cur_wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (tick)   count <= nxt_wide[CNT_W-1:0];
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && count != '0) |=> count == $past(count) - 1'b1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear) |=> count == $past(count));
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && count == '0) |=> count == $past(reload_val));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0);
endmodule

// File: rtl/tick_timer_flag.sv
module tick_timer_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr_wr,
  input  logic clr_rd,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (clr_wr) flag <= 1'b0;
    else if (set)    flag <= 1'b1;
    else if (clr_rd) flag <= 1'b0;
  end

  assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr_wr) |=> flag);
  assert_wrclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !flag);
  assert_rdclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !set) |=> !flag);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_rd && !clr_wr) |=> flag);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int HI_W = DATA_W - CNT_W;

  reg_sel_e         sel;
  logic             wr_ctrl, wr_reload, wr_current, rd_ctrl;
  logic             en_q, irqen_q, src_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count;
  logic             tick, zero_hit, flag;
  logic [DATA_W-1:0] ctrl_view;

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(0): sel = SEL_CTRL;
      ADDR_W'(1): sel = SEL_RELOAD;
      ADDR_W'(2): sel = SEL_CURRENT;
      default:    sel = SEL_NONE;
    endcase
  end

  assign wr_ctrl    = bus_sel &  bus_wr & (sel == SEL_CTRL);
  assign wr_reload  = bus_sel &  bus_wr & (sel == SEL_RELOAD);
  assign wr_current = bus_sel &  bus_wr & (sel == SEL_CURRENT);
  assign rd_ctrl    = bus_sel & ~bus_wr & (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      irqen_q  <= 1'b0;
      src_q    <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q    <= bus_wdata[CTRL_ENABLE];
        irqen_q <= bus_wdata[CTRL_IRQEN];
        src_q   <= bus_wdata[CTRL_SOURCE];
      end
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  tick_timer_src u_src (
    .enable   (en_q),
    .src_core (src_q),
    .ref_tick (ref_tick),
    .tick     (tick)
  );

  tick_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .clear      (wr_current),
    .reload_val (reload_q),
    .count      (count),
    .zero_hit   (zero_hit)
  );

  tick_timer_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (zero_hit),
    .clr_wr (wr_current),
    .clr_rd (rd_ctrl),
    .flag   (flag)
  );

  always_comb begin
    ctrl_view              = '0;
    ctrl_view[CTRL_ENABLE] = en_q;
    ctrl_view[CTRL_IRQEN]  = irqen_q;
    ctrl_view[CTRL_SOURCE] = src_q;
    ctrl_view[CTRL_FLAG]   = flag;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (sel)
        SEL_CTRL:    bus_rdata = ctrl_view;
        SEL_RELOAD:  bus_rdata = {{HI_W{1'b0}}, reload_q};
        SEL_CURRENT: bus_rdata = {{HI_W{1'b0}}, count};
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign irq = flag & irqen_q;

  assert_irqdrop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_current |=> !irq);
  assert_noreload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q == '0 && count == '0 && !wr_reload) |=> count == '0);
endmodule

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench model
  bit        m_en, m_ie, m_src, m_flag;
  bit [23:0] m_rel, m_cur;

  always #10 clk = ~clk;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic bit [31:0] model_read(input bit [1:0] a);
    case (a)
      2'd0: return (32'(m_flag) << 16) | (32'(m_src) << 2) | (32'(m_ie) << 1) | 32'(m_en);
      2'd1: return {8'h00, m_rel};
      2'd2: return {8'h00, m_cur};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input bit [31:0] got, input bit [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // one bus cycle; returns read data seen in the cycle, updates model at the edge
  task automatic op(input bit sel, input bit wr, input bit [1:0] a, input bit [31:0] wd,
                    input bit rf, input string req, output bit [31:0] seen);
    bit ticked, hit;
    bit [23:0] after;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd; ref_tick = rf;
    #1;
    seen = bus_rdata;
    if (sel && !wr) check(req, bus_rdata, model_read(a));
    // model update from the requirements
    ticked = m_en && (m_src || rf);
    after  = m_cur;
    hit    = 1'b0;
    if (ticked) begin
      if (m_cur == 24'd0) after = m_rel;
      else begin after = m_cur - 24'd1; hit = (after == 24'd0); end
    end
    @(posedge clk);
    if (sel && wr && a == 2'd2) begin m_cur = 24'd0; m_flag = 1'b0; end
    else begin
      m_cur = after;
      if (hit) m_flag = 1'b1;
      else if (sel && !wr && a == 2'd0) m_flag = 1'b0;
    end
    if (sel && wr && a == 2'd0) begin m_en = wd[0]; m_ie = wd[1]; m_src = wd[2]; end
    if (sel && wr && a == 2'd1) m_rel = wd[23:0];
    #2;
    check("R8 irq", 32'(irq), 32'(m_flag && m_ie));
  endtask

  task automatic wr_reg(input bit [1:0] a, input bit [31:0] d);
    bit [31:0] s;
    op(1, 1, a, d, 0, "wr", s);
  endtask
  task automatic rd_reg(input bit [1:0] a, input string req, output bit [31:0] s);
    op(1, 0, a, 0, 0, req, s);
  endtask
  task automatic idle(input int n, input bit rf);
    bit [31:0] s;
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, rf, "idle", s);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit [31:0] s;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    rd_reg(0, "R1 ctrl", s);    check("R1 ctrl literal", s, 32'd0);
    rd_reg(1, "R1 reload", s);
    rd_reg(2, "R1 current", s); check("R1 current literal", s, 32'd0);

    // R9 / R11 masking
    wr_reg(1, 32'hAB123456);
    rd_reg(1, "R9 reload", s);  check("R9 reload upper", s, 32'h00123456);
    wr_reg(0, 32'hFFFF0FF8);
    rd_reg(0, "R11 ctrl", s);   check("R11 ctrl unused", s, 32'd0);
    rd_reg(3, "R11 word3", s);  check("R11 word3", s, 32'd0);
    wr_reg(2, 32'hFFFFFFFF);
    rd_reg(2, "R9 current", s); check("R9 current write", s, 32'd0);

    // R4/R5/R7: delay of 5 ticks, read on the wrap edge
    wr_reg(1, 32'd4);
    wr_reg(0, 32'h5);
    wr_reg(2, 32'd0);
    idle(3, 0);
    rd_reg(2, "R2 current", s);  check("R2 count 2", s, 32'd2);
    rd_reg(0, "R7 on wrap", s);  check("R7 before wrap", s, 32'h5);
    rd_reg(0, "R4 flag", s);     check("R4 flag kept", s, 32'h10005);
    rd_reg(0, "R7 cleared", s);  check("R7 cleared", s, 32'h5);
    rd_reg(2, "R5 reload", s);   check("R5 reloaded", s, 32'd3);

    // R6: current write on the wrap edge wins; R8 irq
    wr_reg(0, 32'h7);
    wr_reg(2, 32'd0);
    idle(4, 0);
    wr_reg(2, 32'd0);
    rd_reg(0, "R6 wr wins", s);  check("R6 no flag", s, 32'h7);
    idle(5, 0);
    check("R8 irq high", 32'(irq), 32'd1);
    wr_reg(2, 32'd0);
    check("R8 irq dropped", 32'(irq), 32'd0);

    // R3 reference source
    wr_reg(0, 32'h1);
    wr_reg(1, 32'd9);
    wr_reg(2, 32'd0);
    idle(5, 0);
    rd_reg(2, "R3 no ref", s);   check("R3 held", s, 32'd0);
    idle(1, 1);
    idle(3, 0);
    rd_reg(2, "R3 one ref", s);  check("R3 loaded", s, 32'd9);
    idle(1, 1);
    rd_reg(2, "R3 step", s);     check("R3 step", s, 32'd8);

    // R2 disabled holds
    wr_reg(0, 32'h4);
    idle(6, 1);
    rd_reg(2, "R2 disabled", s); check("R2 hold", s, 32'd8);

    // R10 zero reload
    wr_reg(1, 32'd0);
    wr_reg(0, 32'h5);
    wr_reg(2, 32'd0);
    idle(12, 0);
    rd_reg(0, "R10 no flag", s); check("R10 flag", s, 32'h5);
    rd_reg(2, "R10 cur", s);     check("R10 zero", s, 32'd0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int k;
      bit [31:0] wd;
      bit rf;
      k  = $urandom_range(0, 99);
      rf = ($urandom_range(0, 3) == 0);
      if (k < 4)       begin wd = $urandom(); wd[0] = ($urandom_range(0, 4) != 0); op(1, 1, 0, wd, rf, "R2 rnd", s); end
      else if (k < 8)  op(1, 1, 1, {$urandom_range(0, 255), 24'($urandom_range(0, 12))}, rf, "R5 rnd", s);
      else if (k < 10) op(1, 1, 2, $urandom(), rf, "R6 rnd", s);
      else if (k < 30) op(1, 0, 2'($urandom_range(0, 3)), 0, rf, "R7 rnd read", s);
      else             op(0, 0, 0, 0, rf, "idle", s);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule